// File: doc/BRIEF.md
# E1 HDLC Transmit Bit Insertion Selector

This block sits in the transmit path of an E1 framer. On every bit time it decides whether the outgoing serial bit is the normal payload bit or a bit taken from a transmit HDLC controller. When it takes an HDLC bit, it raises a one-clock pull strobe so that the controller moves to its next bit. Frame timing comes in as a bit-time strobe, a 5-bit timeslot index, a 3-bit bit index in send order and a flag that marks frames without the frame alignment signal.

There are two routings. In the first, HDLC data fills a chosen subset of the spare bits Sa4..Sa8 of timeslot 0, and only in frames without the alignment signal. In the second, HDLC data fills DS0 channels. The channels are picked either by a single 5-bit channel number or by a 32-bit per-timeslot mask. An 8-bit suppress mask then keeps chosen bit positions of each selected channel as payload.

The enable, route, channel-mode, select field and suppress mask are held in a shadow copy that reloads only at the first bit of timeslot 0, so a frame never mixes two configurations. The channel mask is read live on every bit time.

Top module: `e1_hdlc_tx_insert`

## Requirements
- R1: While the latched enable is 0, pull_o never asserts and tx_o repeats the payload bit, whatever the route, mode, field and masks hold.
- R2: With enable=1 and route=0 (Sa route), a bit is replaced when ts_idx_i=0, nfas_i=1 and the field bit for that position is set: field bit 4 enables bit_idx_i=3 (Sa4), bit 3 enables 4 (Sa5), bit 2 enables 5 (Sa6), bit 1 enables 6 (Sa7), bit 0 enables 7 (Sa8). bit_idx_i=0 is the first bit sent (the MSB).
- R3: In the Sa route, no bit is replaced when nfas_i=0 (alignment frames), in timeslots other than 0, or at bit_idx_i 0 to 2, and the suppress mask has no effect.
- R4: With enable=1, route=1 and ch_mode=0, only the timeslot whose index equals the 5-bit field carries HDLC data.
- R5: With enable=1, route=1 and ch_mode=1, every timeslot whose bit is set in ch_mask_i (bit n for timeslot n) carries HDLC data, and ch_mask_i is used as sampled on the same bit time, not latched.
- R6: In the DS0 route, suppress mask bit 7-k, when set, keeps bit_idx_i=k as payload with no pull. Mask bit 7 covers the MSB (k=0) and mask bit 0 the LSB (k=7).
- R7: pull_o is high for exactly one clock, in the cycle after each bit_en_i cycle whose bit is replaced, and low at all other times.
- R8: On the cycle after bit_en_i, tx_o equals the hdlc_bit_i value sampled with bit_en_i when the bit is replaced, and the pay_bit_i value sampled with bit_en_i otherwise.
- R9: The enable, route, mode, field and suppress inputs are latched at the bit time with ts_idx_i=0 and bit_idx_i=0. That bit already uses the new values, and changes made mid-frame act only from the next frame.
- R10: During reset, pull_o and tx_o are 0 and the latched configuration is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-clock strobe per transmitted bit time |
| ts_idx_i | input | 5 | Timeslot index of the current bit |
| bit_idx_i | input | 3 | Bit index in send order, 0 is the MSB |
| nfas_i | input | 1 | 1 in frames without the alignment signal |
| hdlc_en_i | input | 1 | Insertion enable |
| route_ds0_i | input | 1 | 0 selects the Sa route, 1 selects the DS0 route |
| ch_mode_i | input | 1 | DS0 route: 0 uses a single channel number, 1 uses the mask |
| sel_field_i | input | 5 | Sa enables or single channel number |
| supp_mask_i | input | 8 | Per-bit suppress inside each DS0 |
| ch_mask_i | input | 32 | Per-timeslot DS0 select |
| hdlc_bit_i | input | 1 | Current bit offered by the HDLC controller |
| pay_bit_i | input | 1 | Normal payload bit |
| pull_o | output | 1 | Advance the HDLC controller by one bit |
| tx_o | output | 1 | Transmit data bit |

## Verification
A wrong latched configuration or a wrong decode shows at the ports as pull_o asserting in a timeslot or bit position where it must not, or staying low where it must assert. The same fault puts the wrong source on tx_o one clock after the affected bit_en_i. The bench predicts every strobe and data bit over whole frames for each route and mode, so such a fault is caught on the first bit time it touches. A shadow register that reloads at the wrong moment shows up within the frame in which the control changes mid-frame.

// File: rtl/e1_hdlc_ins_pkg.sv
package e1_hdlc_ins_pkg;
  localparam int unsigned N_TS   = 32;
  localparam int unsigned TS_W   = $clog2(N_TS);
  localparam int unsigned N_BITS = 8;
  localparam int unsigned BIT_W  = $clog2(N_BITS);
  localparam int unsigned SA_N   = 5;

  typedef struct packed {
    logic              en;
    logic              route_ds0;
    logic              ch_mode;
    logic [TS_W-1:0]   field;
    logic [N_BITS-1:0] supp;
  } ins_cfg_t;
endpackage

// File: rtl/e1_hdlc_ins_cfg.sv
module e1_hdlc_ins_cfg
  import e1_hdlc_ins_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     bit_en_i,
  input  logic     frame_start_i,
  input  ins_cfg_t cfg_in_i,
  output ins_cfg_t cfg_cur_o,
  output ins_cfg_t cfg_q_o
);
  logic take;
  assign take      = bit_en_i && frame_start_i;
  // the boundary bit already uses the incoming configuration
  assign cfg_cur_o = take ? cfg_in_i : cfg_q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q_o <= '0;
    else if (take) cfg_q_o <= cfg_in_i;
  end
endmodule

// File: rtl/e1_hdlc_ins_sa.sv
module e1_hdlc_ins_sa
  import e1_hdlc_ins_pkg::*;
(
  input  logic             en_i,
  input  logic             route_ds0_i,
  input  logic [TS_W-1:0]  field_i,
  input  logic [TS_W-1:0]  ts_idx_i,
  input  logic [BIT_W-1:0] bit_idx_i,
  input  logic             nfas_i,
  output logic             hit_o
);
  logic [SA_N-1:0] pos_hit;

  // field bit g enables send position N_BITS-1-g (bit 0 -> last bit, Sa8)
  for (genvar g = 0; g < SA_N; g++) begin : g_pos
    assign pos_hit[g] = field_i[g] && (bit_idx_i == BIT_W'(N_BITS - 1 - g));
  end

  assign hit_o = en_i && !route_ds0_i && nfas_i &&
                 (ts_idx_i == '0) && (|pos_hit);
endmodule

// File: rtl/e1_hdlc_ins_ds0.sv
module e1_hdlc_ins_ds0
  import e1_hdlc_ins_pkg::*;
(
  input  logic              en_i,
  input  logic              route_ds0_i,
  input  logic              ch_mode_i,
  input  logic [TS_W-1:0]   field_i,
  input  logic [N_BITS-1:0] supp_i,
  input  logic [N_TS-1:0]   ch_mask_i,
  input  logic [TS_W-1:0]   ts_idx_i,
  input  logic [BIT_W-1:0]  bit_idx_i,
  output logic              hit_o
);
  logic [N_TS-1:0]   ts_oh;
  logic [N_TS-1:0]   single_oh;
  logic [N_TS-1:0]   chan_vec;
  logic [N_BITS-1:0] pos_oh;
  logic              chan_hit;
  logic              supp_hit;

  for (genvar t = 0; t < N_TS; t++) begin : g_ts
    assign ts_oh[t]     = (ts_idx_i == TS_W'(t));
    assign single_oh[t] = (field_i == TS_W'(t));
  end

  // mask bit g covers send position N_BITS-1-g (MSB first)
  for (genvar g = 0; g < N_BITS; g++) begin : g_bit
    assign pos_oh[g] = (bit_idx_i == BIT_W'(N_BITS - 1 - g));
  end

  assign chan_vec = ch_mode_i ? ch_mask_i : single_oh;
  assign chan_hit = |(ts_oh & chan_vec);
  assign supp_hit = |(pos_oh & supp_i);
  assign hit_o    = en_i && route_ds0_i && chan_hit && !supp_hit;
endmodule

// File: rtl/e1_hdlc_ins_out.sv
module e1_hdlc_ins_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic sel_i,
  input  logic hdlc_bit_i,
  input  logic pay_bit_i,
  output logic pull_o,
  output logic tx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pull_o <= 1'b0;
      tx_o   <= 1'b0;
    end else begin
      pull_o <= bit_en_i && sel_i;
      if (bit_en_i) tx_o <= sel_i ? hdlc_bit_i : pay_bit_i;
    end
  end
endmodule

// File: rtl/e1_hdlc_tx_insert.sv
module e1_hdlc_tx_insert
  import e1_hdlc_ins_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic [TS_W-1:0]   ts_idx_i,
  input  logic [BIT_W-1:0]  bit_idx_i,
  input  logic              nfas_i,
  input  logic              hdlc_en_i,
  input  logic              route_ds0_i,
  input  logic              ch_mode_i,
  input  logic [TS_W-1:0]   sel_field_i,
  input  logic [N_BITS-1:0] supp_mask_i,
  input  logic [N_TS-1:0]   ch_mask_i,
  input  logic              hdlc_bit_i,
  input  logic              pay_bit_i,
  output logic              pull_o,
  output logic              tx_o
);
  ins_cfg_t cfg_in, cfg_cur, cfg_q;
  logic     frame_start, sa_hit, ds0_hit, sel;

  assign frame_start = (ts_idx_i == '0) && (bit_idx_i == '0);
  assign cfg_in = '{en: hdlc_en_i, route_ds0: route_ds0_i, ch_mode: ch_mode_i,
                    field: sel_field_i, supp: supp_mask_i};

  e1_hdlc_ins_cfg u_cfg (
    .clk_i, .rst_ni, .bit_en_i,
    .frame_start_i (frame_start),
    .cfg_in_i      (cfg_in),
    .cfg_cur_o     (cfg_cur),
    .cfg_q_o       (cfg_q)
  );

  e1_hdlc_ins_sa u_sa (
    .en_i        (cfg_cur.en),
    .route_ds0_i (cfg_cur.route_ds0),
    .field_i     (cfg_cur.field),
    .ts_idx_i, .bit_idx_i, .nfas_i,
    .hit_o       (sa_hit)
  );

  e1_hdlc_ins_ds0 u_ds0 (
    .en_i        (cfg_cur.en),
    .route_ds0_i (cfg_cur.route_ds0),
    .ch_mode_i   (cfg_cur.ch_mode),
    .field_i     (cfg_cur.field),
    .supp_i      (cfg_cur.supp),
    .ch_mask_i, .ts_idx_i, .bit_idx_i,
    .hit_o       (ds0_hit)
  );

  assign sel = sa_hit || ds0_hit;

  e1_hdlc_ins_out u_out (
    .clk_i, .rst_ni, .bit_en_i,
    .sel_i (sel),
    .hdlc_bit_i, .pay_bit_i, .pull_o, .tx_o
  );
endmodule

// File: rtl/e1_hdlc_ins_chk.sv
module e1_hdlc_ins_chk
  import e1_hdlc_ins_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bit_en_i,
  input logic [TS_W-1:0]   ts_idx_i,
  input logic [BIT_W-1:0]  bit_idx_i,
  input logic              nfas_i,
  input logic [N_TS-1:0]   ch_mask_i,
  input logic              hdlc_bit_i,
  input logic              pay_bit_i,
  input logic              pull_o,
  input logic              tx_o,
  input logic              frame_start,
  input ins_cfg_t          cfg_cur,
  input ins_cfg_t          cfg_q
);
  ins_cfg_t          cur_d;
  logic [TS_W-1:0]   ts_d;
  logic [BIT_W-1:0]  bit_d;
  logic [N_TS-1:0]   mask_d;
  logic              en_d, nfas_d, hdlc_d, pay_d, fs_d;
  logic [N_BITS-1:0] field_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_d <= '0; ts_d <= '0; bit_d <= '0; mask_d <= '0;
      en_d <= 1'b0; nfas_d <= 1'b0; hdlc_d <= 1'b0; pay_d <= 1'b0; fs_d <= 1'b0;
    end else begin
      cur_d <= cfg_cur; ts_d <= ts_idx_i; bit_d <= bit_idx_i; mask_d <= ch_mask_i;
      en_d <= bit_en_i; nfas_d <= nfas_i; hdlc_d <= hdlc_bit_i; pay_d <= pay_bit_i;
      fs_d <= frame_start;
    end
  end

  assign field_ext = {{(N_BITS-TS_W){1'b0}}, cur_d.field};

  assert_disabled_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_o |-> cur_d.en);
  assert_sa_field_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_o && !cur_d.route_ds0 && bit_d >= 3) |-> field_ext[~bit_d]);
  assert_sa_place_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_o && !cur_d.route_ds0) |-> (nfas_d && ts_d == '0 && bit_d >= 3));
  assert_single_ch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_o && cur_d.route_ds0 && !cur_d.ch_mode) |-> (ts_d == cur_d.field));
  assert_mask_ch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_o && cur_d.route_ds0 && cur_d.ch_mode) |-> mask_d[ts_d]);
  assert_suppress_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_o && cur_d.route_ds0) |-> !cur_d.supp[~bit_d]);
  assert_pull_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_o |-> en_d);
  assert_tx_hdlc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_o |-> (tx_o == hdlc_d));
  assert_tx_pay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_d && !pull_o) |-> (tx_o == pay_d));
  assert_cfg_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_d && fs_d) |-> $stable(cfg_q));
endmodule

bind e1_hdlc_tx_insert e1_hdlc_ins_chk u_chk (
  .clk_i, .rst_ni, .bit_en_i, .ts_idx_i, .bit_idx_i, .nfas_i, .ch_mask_i,
  .hdlc_bit_i, .pay_bit_i, .pull_o, .tx_o,
  .frame_start (frame_start),
  .cfg_cur     (cfg_cur),
  .cfg_q       (cfg_q)
);

// File: tb/e1_hdlc_tx_insert_test.sv
`timescale 1ns/1ps
module e1_hdlc_tx_insert_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_en_i = 1'b0;
  logic [4:0]  ts_idx_i = '0;
  logic [2:0]  bit_idx_i = '0;
  logic        nfas_i = 1'b0;
  logic        hdlc_en_i = 1'b0, route_ds0_i = 1'b0, ch_mode_i = 1'b0;
  logic [4:0]  sel_field_i = '0;
  logic [7:0]  supp_mask_i = '0;
  logic [31:0] ch_mask_i = '0;
  logic        hdlc_bit_i = 1'b0, pay_bit_i = 1'b0;
  logic        pull_o, tx_o;

  always #2.5 clk_i = ~clk_i;

  e1_hdlc_tx_insert uut (.*);

  typedef struct { bit pull; bit tx; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0, dut_pulls = 0, exp_pulls = 0;
  bit done = 0;

  // model state: latched configuration
  bit m_en, m_route, m_mode;
  bit [4:0] m_field;
  bit [7:0] m_supp;
  // alternate control values applied mid-frame
  bit a_en, a_route, a_mode;
  bit [4:0] a_field;
  bit [7:0] a_supp;
  bit [31:0] a_mask;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: compare one item per bit time, and pull low otherwise (R7)
  initial begin
    forever begin
      bit cap;
      exp_t e;
      @(posedge clk_i);
      cap = bit_en_i;
      @(negedge clk_i);
      if (cap && q.size() > 0) begin
        e = q.pop_front();
        if (pull_o) dut_pulls++;
        chk(pull_o == e.pull, e.tag, "pull", pull_o, e.pull);
        chk(tx_o == e.tx, "R8", "tx", tx_o, e.tx);
      end else if (rst_ni) begin
        chk(pull_o == 1'b0, "R7", "idle pull", pull_o, 0);
      end
    end
  end

  task automatic drive_bit(input int ts, input int b, input bit nfas, input string tag);
    bit sel;
    exp_t e;
    @(negedge clk_i);
    ts_idx_i   = 5'(ts);
    bit_idx_i  = 3'(b);
    nfas_i     = nfas;
    pay_bit_i  = 1'($urandom);
    hdlc_bit_i = 1'($urandom);
    bit_en_i   = 1'b1;
    if (ts == 0 && b == 0) begin  // R9 boundary latch
      m_en = hdlc_en_i; m_route = route_ds0_i; m_mode = ch_mode_i;
      m_field = sel_field_i; m_supp = supp_mask_i;
    end
    sel = 1'b0;
    if (m_en && !m_route)
      sel = nfas && ts == 0 && b >= 3 && m_field[7 - b];
    else if (m_en && m_route)
      sel = (m_mode ? ch_mask_i[ts] : (int'(m_field) == ts)) && !m_supp[7 - b];
    if (sel) exp_pulls++;
    e.pull = sel;
    e.tx   = sel ? hdlc_bit_i : pay_bit_i;
    e.tag  = tag;
    q.push_back(e);
    @(negedge clk_i);
    bit_en_i = 1'b0;
  endtask

  task automatic run_frame(input bit nfas, input string tag, input int swap_ts);
    dut_pulls = 0;
    exp_pulls = 0;
    for (int ts = 0; ts < 32; ts++) begin
      for (int b = 0; b < 8; b++) begin
        if (ts == swap_ts && b == 0) begin
          hdlc_en_i = a_en; route_ds0_i = a_route; ch_mode_i = a_mode;
          sel_field_i = a_field; supp_mask_i = a_supp; ch_mask_i = a_mask;
        end
        drive_bit(ts, b, nfas, tag);
      end
    end
    @(negedge clk_i);
    while (q.size() != 0) @(negedge clk_i);
    chk(dut_pulls == exp_pulls, "R7", "pulls per frame", dut_pulls, exp_pulls);
  endtask

  task automatic set_cfg(input bit en, input bit route, input bit mode,
                         input bit [4:0] field, input bit [7:0] supp, input bit [31:0] mask);
    @(negedge clk_i);
    hdlc_en_i = en; route_ds0_i = route; ch_mode_i = mode;
    sel_field_i = field; supp_mask_i = supp; ch_mask_i = mask;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(pull_o == 1'b0, "R10", "reset pull", pull_o, 0);
    chk(tx_o == 1'b0, "R10", "reset tx", tx_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: disabled, route fields loaded with values that would select
    set_cfg(0, 1, 1, 5'd3, 8'h00, 32'hFFFF_FFFF);
    run_frame(1, "R1", -1);
    set_cfg(0, 0, 0, 5'h1F, 8'h00, 32'hFFFF_FFFF);
    run_frame(1, "R1", -1);

    // R2/R3: Sa4, Sa6, Sa8; suppress mask must not matter
    set_cfg(1, 0, 0, 5'b10101, 8'hFF, 32'hFFFF_FFFF);
    run_frame(0, "R3", -1);
    run_frame(1, "R2", -1);
    set_cfg(1, 0, 0, 5'b01011, 8'h00, 32'h0);
    run_frame(1, "R2", -1);
    run_frame(0, "R3", -1);

    // R4: single channel by number
    set_cfg(1, 1, 0, 5'd17, 8'h00, 32'h0000_0001);
    run_frame(0, "R4", -1);
    set_cfg(1, 1, 0, 5'd31, 8'h00, 32'h0);
    run_frame(1, "R4", -1);
    set_cfg(1, 1, 0, 5'd0, 8'h00, 32'h0);
    run_frame(0, "R4", -1);

    // R6: suppress MSB and LSB, then everything
    set_cfg(1, 1, 0, 5'd17, 8'b1000_0001, 32'h0);
    run_frame(1, "R6", -1);
    set_cfg(1, 1, 1, 5'd0, 8'b0110_0000, 32'h0000_F00F);
    run_frame(0, "R6", -1);
    set_cfg(1, 1, 0, 5'd9, 8'hFF, 32'h0);
    run_frame(1, "R6", -1);

    // R5: mask mode, mask changed mid-frame is used at once
    set_cfg(1, 1, 1, 5'd4, 8'h00, 32'h8000_0006);
    a_en = 1; a_route = 1; a_mode = 1; a_field = 5'd4; a_supp = 8'h00; a_mask = 32'h0012_0000;
    run_frame(1, "R5", 16);
    run_frame(0, "R5", -1);

    // R9: mid-frame change to disabled keeps channel 5 for this frame
    set_cfg(1, 1, 0, 5'd5, 8'h00, 32'h0);
    a_en = 0; a_route = 0; a_mode = 0; a_field = 5'd0; a_supp = 8'h00; a_mask = 32'h0;
    run_frame(1, "R9", 3);
    run_frame(1, "R9", -1);
    // R9: mid-frame switch from Sa to DS0 channel 2 acts next frame only
    set_cfg(1, 0, 0, 5'b11111, 8'h00, 32'h0);
    a_en = 1; a_route = 1; a_mode = 0; a_field = 5'd2; a_supp = 8'h00; a_mask = 32'h0;
    run_frame(1, "R9", 1);
    run_frame(1, "R9", -1);

    finish_run();
  end
endmodule